// File: doc/BRIEF.md
# Link Width and Control Configuration Register

This block is a single 32-bit configuration word for a serial point-to-point link controller. Software programs the outgoing and incoming link widths and two link-control bits through a byte-enabled write port. It reads the whole word back through a combinational read port. Hardware reports detected CRC errors into a sticky flag, and software clears that flag by writing a one to it.

Each direction holds two copies of its width. The programmed copy is what software sees and writes. The active copy is what drives the link logic. The active copy follows the programmed one only when a disconnect sequence completes or while the warm reset is held low.

A width write that carries an unsupported code is dropped for that field alone. The block has two reset inputs. The power-good reset clears every field. The warm reset clears nothing and only loads the active widths.

Top module: `lnkctl_cfg`

## Requirements
- R1: While the power-good reset is low, and after it is released, the readback word is zero except for the width fields. Both programmed widths and both active widths equal the parameter RST_WIDTH, which defaults to 000.
- R2: A write with byte lane 3 enabled and a legal code stores that code. The outgoing width is in bits 30:28 and the incoming width is in bits 26:24. The legal codes are 000 (8 lanes), 100 (2 lanes) and 101 (4 lanes).
- R3: A write with byte lane 3 enabled leaves a width field unchanged when that field's code is any other value. The check is made per field: the other field is still updated if its own code is legal.
- R4: A register write never changes the active widths.
- R5: At the clock edge where the disconnect-done pulse is high, or at any edge while the warm reset is low, each active width takes the programmed value sampled at that edge.
- R6: The warm reset leaves the programmed widths, bits 14 and 13, and the CRC flag unchanged.
- R7: Bit 14 (extended control hold) and bit 13 (transmitter high-impedance enable) are read-write through byte lane 1.
- R8: Bit 8 is set by the CRC-error strobe. A write with lane 1 enabled and bit 8 at one clears it. A write with bit 8 at zero leaves it unchanged.
- R9: If the CRC-error strobe and a clearing write fall on the same edge, bit 8 ends up set.
- R10: When a byte lane's enable is low, the write changes nothing in that byte.
- R11: The maximum-width fields (bits 22:20 outgoing, 18:16 incoming) always read 000. Bits 31, 27, 23, 19, 15, 12:9 and 7:0 read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Power-good reset, asynchronous, active low |
| warm_rst_n | input | 1 | Warm reset level, active low, sampled on clk |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 4 | Byte-lane enables for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register contents |
| crc_err_set | input | 1 | Hardware CRC-error strobe |
| disc_done | input | 1 | Disconnect-sequence complete pulse |
| act_width_out | output | 3 | Active outgoing width code |
| act_width_in | output | 3 | Active incoming width code |

## Verification
The properties take the power-good reset as the only event that disturbs the register asynchronously. They treat the disconnect-done pulse and the warm reset as sampled levels, so holding either one for several cycles just repeats the load. The properties place no limit on how writes, CRC strobes and load events overlap. The stimulus changes every input on the falling clock edge only. It deliberately overlaps a CRC strobe with a clearing write, and it drives illegal codes into one width field while the other field gets a legal code.

// File: rtl/lnkctl_pkg.sv
package lnkctl_pkg;

   localparam int REG_W       = 32;
   localparam int CODE_W      = 3;
   localparam int OUT_LSB     = 28;
   localparam int IN_LSB      = 24;
   localparam int MAX_OUT_LSB = 20;
   localparam int MAX_IN_LSB  = 16;
   localparam int EXT_BIT     = 14;
   localparam int HIZ_BIT     = 13;
   localparam int CRC_BIT     = 8;
   localparam int NUM_DIR     = 2;

   localparam logic [CODE_W-1:0] CODE_8LANE = 3'b000;
   localparam logic [CODE_W-1:0] CODE_2LANE = 3'b100;
   localparam logic [CODE_W-1:0] CODE_4LANE = 3'b101;

   function automatic logic width_legal(input logic [CODE_W-1:0] c);
      return (c == CODE_8LANE) || (c == CODE_2LANE) || (c == CODE_4LANE);
   endfunction

   function automatic int dir_lsb(input int d);
      return (d == 0) ? OUT_LSB : IN_LSB;
   endfunction

endpackage

// File: rtl/lnkctl_width_field.sv
module lnkctl_width_field
   import lnkctl_pkg::*;
#(
   parameter logic [CODE_W-1:0] RST_CODE = CODE_8LANE
) (
   input  logic              clk,
   input  logic              pwr_rst_n,
   input  logic              wr_stb,
   input  logic [CODE_W-1:0] wr_code,
   input  logic              load,
   output logic [CODE_W-1:0] prog_code,
   output logic [CODE_W-1:0] act_code
);

   logic accept;
   assign accept = wr_stb && width_legal(wr_code);

   always_ff @(posedge clk or negedge pwr_rst_n) begin
      if (!pwr_rst_n) begin
         prog_code <= RST_CODE;
      end else if (accept) begin
         prog_code <= wr_code;
      end
   end

   always_ff @(posedge clk or negedge pwr_rst_n) begin
      if (!pwr_rst_n) begin
         act_code <= RST_CODE;
      end else if (load) begin
         act_code <= prog_code;
      end
   end

endmodule

// File: rtl/lnkctl_ctrl_bits.sv
module lnkctl_ctrl_bits #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic pwr_rst_n,
   input  logic wr_stb,
   input  logic wr_ext,
   input  logic wr_hiz,
   input  logic wr_crc_clr,
   input  logic crc_set,
   output logic ext_hold,
   output logic hiz_en,
   output logic crc_flag
);

   logic crc_nxt;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb begin
            if (crc_set)                  crc_nxt = 1'b1;
            else if (wr_stb && wr_crc_clr) crc_nxt = 1'b0;
            else                          crc_nxt = crc_flag;
         end
      end else begin : g_clr_first
         always_comb begin
            if (wr_stb && wr_crc_clr) crc_nxt = 1'b0;
            else if (crc_set)         crc_nxt = 1'b1;
            else                      crc_nxt = crc_flag;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge pwr_rst_n) begin
      if (!pwr_rst_n) begin
         ext_hold <= 1'b0;
         hiz_en   <= 1'b0;
         crc_flag <= 1'b0;
      end else begin
         if (wr_stb) begin
            ext_hold <= wr_ext;
            hiz_en   <= wr_hiz;
         end
         crc_flag <= crc_nxt;
      end
   end

endmodule

// File: rtl/lnkctl_cfg.sv
module lnkctl_cfg
   import lnkctl_pkg::*;
#(
   parameter logic [2:0] RST_WIDTH    = 3'b000,
   parameter bit         CRC_SET_WINS = 1'b1
) (
   input  logic        clk,
   input  logic        pwr_rst_n,
   input  logic        warm_rst_n,
   input  logic        wr_en,
   input  logic [3:0]  wr_be,
   input  logic [31:0] wr_data,
   output logic [31:0] rd_data,
   input  logic        crc_err_set,
   input  logic        disc_done,
   output logic [2:0]  act_width_out,
   output logic [2:0]  act_width_in
);

   localparam int LANE_W     = 8;
   localparam int WIDTH_LANE = OUT_LSB / LANE_W;
   localparam int CTRL_LANE  = EXT_BIT / LANE_W;
   localparam logic [CODE_W-1:0] MAX_CODE = CODE_8LANE;

   generate
      if (!width_legal(RST_WIDTH)) begin : g_bad_rst
         $error("lnkctl_cfg: RST_WIDTH is not a supported width code");
      end
      if ((IN_LSB / LANE_W) != WIDTH_LANE || (CRC_BIT / LANE_W) != CTRL_LANE) begin : g_bad_lane
         $error("lnkctl_cfg: field layout crosses byte lanes");
      end
   endgenerate

   logic              load_act;
   logic              width_stb;
   logic              ctrl_stb;
   logic [CODE_W-1:0] prog_w [NUM_DIR];
   logic [CODE_W-1:0] act_w  [NUM_DIR];
   logic              ext_hold, hiz_en, crc_flag;
   logic              wr_data_unused;

   assign load_act  = !warm_rst_n || disc_done;
   assign width_stb = wr_en && wr_be[WIDTH_LANE];
   assign ctrl_stb  = wr_en && wr_be[CTRL_LANE];
   assign wr_data_unused = ^{wr_data[31], wr_data[27], wr_data[23:15],
                             wr_data[12:9], wr_data[7:0], wr_be[0], wr_be[2]};

   generate
      for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
         localparam int LSB = dir_lsb(d);
         lnkctl_width_field #(.RST_CODE(RST_WIDTH)) u_fld (
            .clk       (clk),
            .pwr_rst_n (pwr_rst_n),
            .wr_stb    (width_stb),
            .wr_code   (wr_data[LSB +: CODE_W]),
            .load      (load_act),
            .prog_code (prog_w[d]),
            .act_code  (act_w[d])
         );
      end
   endgenerate

   lnkctl_ctrl_bits #(.SET_WINS(CRC_SET_WINS)) u_ctl (
      .clk        (clk),
      .pwr_rst_n  (pwr_rst_n),
      .wr_stb     (ctrl_stb),
      .wr_ext     (wr_data[EXT_BIT]),
      .wr_hiz     (wr_data[HIZ_BIT]),
      .wr_crc_clr (wr_data[CRC_BIT]),
      .crc_set    (crc_err_set),
      .ext_hold   (ext_hold),
      .hiz_en     (hiz_en),
      .crc_flag   (crc_flag)
   );

   always_comb begin
      rd_data                          = '0;
      rd_data[OUT_LSB +: CODE_W]       = prog_w[0];
      rd_data[IN_LSB +: CODE_W]        = prog_w[1];
      rd_data[MAX_OUT_LSB +: CODE_W]   = MAX_CODE;
      rd_data[MAX_IN_LSB +: CODE_W]    = MAX_CODE;
      rd_data[EXT_BIT]                 = ext_hold;
      rd_data[HIZ_BIT]                 = hiz_en;
      rd_data[CRC_BIT]                 = crc_flag;
   end

   assign act_width_out = act_w[0];
   assign act_width_in  = act_w[1];

endmodule

// File: rtl/lnkctl_cfg_chk.sv
module lnkctl_cfg_chk
   import lnkctl_pkg::*;
(
   input logic        clk,
   input logic        pwr_rst_n,
   input logic        warm_rst_n,
   input logic        wr_en,
   input logic [3:0]  wr_be,
   input logic [31:0] wr_data,
   input logic [31:0] rd_data,
   input logic        crc_err_set,
   input logic        disc_done,
   input logic [2:0]  act_width_out,
   input logic [2:0]  act_width_in
);

   localparam logic [31:0] ZERO_MASK = 32'h88FF_9EFF;

   logic chk_unused;
   assign chk_unused = ^{wr_data[31], wr_data[27:0], wr_be[2:0]};

   a_r3_bad_out_kept: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (wr_en && wr_be[3] && !width_legal(wr_data[30:28]))
      |=> (rd_data[30:28] == $past(rd_data[30:28])));

   a_r4_act_held: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (warm_rst_n && !disc_done) |=> ($stable(act_width_out) && $stable(act_width_in)));

   a_r5_load_copies: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (!warm_rst_n || disc_done)
      |=> (act_width_out == $past(rd_data[30:28]) && act_width_in == $past(rd_data[26:24])));

   a_r8_crc_sets: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      crc_err_set |=> rd_data[8]);

   a_r11_fixed_zero: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (rd_data & ZERO_MASK) == 32'h0);

endmodule

bind lnkctl_cfg lnkctl_cfg_chk u_chk (
   .clk           (clk),
   .pwr_rst_n     (pwr_rst_n),
   .warm_rst_n    (warm_rst_n),
   .wr_en         (wr_en),
   .wr_be         (wr_be),
   .wr_data       (wr_data),
   .rd_data       (rd_data),
   .crc_err_set   (crc_err_set),
   .disc_done     (disc_done),
   .act_width_out (act_width_out),
   .act_width_in  (act_width_in)
);

// File: tb/lnkctl_cfg_bench.sv
module lnkctl_cfg_bench;

   logic        clk = 1'b0;
   logic        pwr_rst_n = 1'b0;
   logic        warm_rst_n = 1'b1;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_be = 4'h0;
   logic [31:0] wr_data = 32'h0;
   logic [31:0] rd_data;
   logic        crc_err_set = 1'b0;
   logic        disc_done = 1'b0;
   logic [2:0]  act_width_out, act_width_in;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   lnkctl_cfg u_lnkctl_cfg (
      .clk(clk), .pwr_rst_n(pwr_rst_n), .warm_rst_n(warm_rst_n),
      .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data),
      .crc_err_set(crc_err_set), .disc_done(disc_done),
      .act_width_out(act_width_out), .act_width_in(act_width_in)
   );

   // {byte enables, write data, expected readback after the write}
   localparam logic [67:0] VEC [10] = '{
      {4'b1000, 32'h4000_0000, 32'h4000_0000},  // R2 out=2 lanes
      {4'b1000, 32'h5500_0000, 32'h5500_0000},  // R2 both 4 lanes
      {4'b1000, 32'h7300_0000, 32'h5500_0000},  // R3 both illegal
      {4'b1000, 32'h1400_0000, 32'h5400_0000},  // R3 out illegal, in legal
      {4'b0111, 32'h0000_6100, 32'h5400_6000},  // R7 set ctrl bits
      {4'b1000, 32'hFFFF_FFFF, 32'h5400_6000},  // R3 R11 all ones
      {4'b0010, 32'h0000_2000, 32'h5400_2000},  // R7 clear bit 14
      {4'b0101, 32'hFFFF_FFFF, 32'h5400_2000},  // R10 lanes off
      {4'b1111, 32'h0000_0000, 32'h0000_0000},  // R2 R7 back to 8 lanes
      {4'b1111, 32'hFFFF_FFFF, 32'h0000_6000}   // R11 R3 all lanes
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic write(input logic [3:0] be, input logic [31:0] d, input logic crc);
      @(negedge clk);
      wr_en = 1'b1; wr_be = be; wr_data = d; crc_err_set = crc;
      @(negedge clk);
      wr_en = 1'b0; wr_be = 4'h0; wr_data = 32'h0; crc_err_set = 1'b0;
   endtask

   task automatic pwr_reset();
      @(negedge clk);
      pwr_rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 readback in reset", rd_data, 32'h0);
      pwr_rst_n = 1'b1;
      @(negedge clk);
   endtask

   function automatic logic [31:0] act();
      return {26'h0, act_width_out, act_width_in};
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      pwr_reset();
      check("R1 readback", rd_data, 32'h0);
      check("R1 active widths", act(), 32'h0);

      for (int i = 0; i < 10; i++) begin
         write(VEC[i][67:64], VEC[i][63:32], 1'b0);
         check($sformatf("R2/R3/R7/R10/R11 vector %0d", i), rd_data, VEC[i][31:0]);
         check($sformatf("R4 active after vector %0d", i), act(), 32'h0);
      end

      write(4'b1000, 32'h4500_0000, 1'b0);
      check("R2 program 2/4", rd_data, 32'h4500_6000);
      check("R4 active unchanged by write", act(), 32'h0);

      @(negedge clk); disc_done = 1'b1;
      @(negedge clk); disc_done = 1'b0;
      check("R5 disconnect loads active", act(), {26'h0, 3'b100, 3'b101});

      @(negedge clk); crc_err_set = 1'b1;
      @(negedge clk); crc_err_set = 1'b0;
      check("R8 crc strobe sets flag", rd_data, 32'h4500_6100);

      write(4'b1000, 32'h5400_0000, 1'b0);
      check("R4 new program pending", act(), {26'h0, 3'b100, 3'b101});

      @(negedge clk); warm_rst_n = 1'b0;
      repeat (2) @(negedge clk);
      warm_rst_n = 1'b1;
      check("R5 warm reset loads active", act(), {26'h0, 3'b101, 3'b100});
      check("R6 warm reset keeps fields", rd_data, 32'h5400_6100);

      write(4'b0010, 32'h0000_6000, 1'b0);
      check("R8 write zero keeps flag", rd_data, 32'h5400_6100);
      write(4'b0010, 32'h0000_6100, 1'b0);
      check("R8 write one clears flag", rd_data, 32'h5400_6000);
      write(4'b0010, 32'h0000_6100, 1'b1);
      check("R9 set beats clear", rd_data, 32'h5400_6100);

      write(4'b0101, 32'hFFFF_FFFF, 1'b0);
      check("R10 R11 disabled lanes", rd_data, 32'h5400_6100);

      pwr_reset();
      check("R1 readback after power reset", rd_data, 32'h0);
      check("R1 active after power reset", act(), 32'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule